// File: doc/BRIEF.md
# Four-Lane Fixed-Coefficient Block FIR Filter Using Shift-Add Constant Multipliers

This block is a 16-tap FIR filter. Every clock it takes four new samples and returns four filtered outputs. The coefficients are fixed when the block is elaborated, and the block has no general multipliers. Each output needs a sliding window of seven samples: the four that have just arrived and the three latest samples of the previous block. Each of the seven window samples feeds one constant-multiplier network built from shifts, adds and subtracts. That network produces every coefficient multiple the sample takes part in. An adder network combines these multiples into sixteen partial inner products, one per (output lane, coefficient column). A transpose-form chain of adders and registers then spreads the later columns across successive blocks.

A sample stream enters four samples at a time with a valid strobe. The filtered stream leaves one clock later, in the same lane order, with its own strobe. When the strobe is low the filter keeps its state, so gaps in the stream do not change the result.

Top module: `fir_mcm_block`

## Requirements
- R1: Reset (active-low `rst_n`, applied asynchronously and released on the clock after two edges) drives `out_valid` to 0 and `out_samples` to 0. It also clears all stored past samples, so later outputs treat every sample before reset as zero.
- R2: Lane i of `in_samples` is bits [8i+7:8i] and holds a signed 8-bit sample. Lane 0 is the earliest sample of the block and lane 3 the latest. Lane i of `out_samples` is bits [24i+23:24i] and equals the sum over t = 0..15 of h(t)·x(n−t), where n is the stream position of input lane i.
- R3: A block accepted at a rising edge with `in_valid` high gives its four results on `out_samples`, with `out_valid` high, right after the next rising edge. The latency is exactly one cycle.
- R4: A cycle with `in_valid` low stores nothing and advances nothing. After it, `out_valid` is low and `out_samples` keeps its previous value.
- R5: A sample in any lane affects outputs in the current block and in the later blocks up to 15 positions after it. This holds across block boundaries, whatever lane the sample arrived in.
- R6: Products are exact signed values across the full range, including −128 × −32768 = +4194304.
- R7: Each output is the exact sum reduced modulo 2^24 and read as a 24-bit two's-complement word.
- R8: Coefficient h(i) sits in bits [16i+15:16i] of parameter `COEFS` as a signed 16-bit value. A unit impulse therefore gives h(0) through h(15) on consecutive output positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A block of four samples is present this cycle |
| in_samples | input | 32 | Four signed 8-bit samples, lane 0 earliest |
| out_valid | output | 1 | A block of four results is present |
| out_samples | output | 96 | Four 24-bit filtered results, lane 0 earliest |

## Verification
The hardest condition to reach from the ports is a sum that wraps past 24 bits. Random full-scale data almost never lines every sample sign up with every coefficient sign. The stimulus therefore builds a 16-sample run in which each sample is +127 or −128, matched to the sign of the coefficient it will meet at one chosen output position. Impulses placed in each lane follow a sample across block boundaries. A reset in the middle of a run, followed by an all-zero block, shows that no history survives reset.

// File: rtl/fir_mcm_pkg.sv
package fir_mcm_pkg;

  // Signed-digit recoding (non-adjacent form) of a constant.
  // With neg = 0 the function returns the mask of +1 digits.
  // With neg = 1 it returns the mask of -1 digits.
  function automatic logic [31:0] csd_mask(input longint value, input bit neg);
    logic [31:0] m;
    longint      r;
    m = '0;
    r = value;
    for (int i = 0; i < 32; i++) begin
      if (r[0]) begin
        if (r[1]) begin
          if (neg) m[i] = 1'b1;
          r = r + 1;
        end else begin
          if (!neg) m[i] = 1'b1;
          r = r - 1;
        end
      end
      r = r >>> 1;
    end
    return m;
  endfunction

endpackage

// File: rtl/fir_csd_mult.sv
module fir_csd_mult
  import fir_mcm_pkg::*;
#(
  parameter int     XW   = 8,
  parameter int     AW   = 24,
  parameter longint COEF = 0
) (
  input  logic signed [XW-1:0] x,
  output logic        [AW-1:0] p
);

  localparam logic [31:0] POS = csd_mask(COEF, 1'b0);
  localparam logic [31:0] NEG = csd_mask(COEF, 1'b1);
  localparam int          ND  = (AW < 32) ? AW : 32;

  logic [AW-1:0] xe;
  logic [AW-1:0] acc [ND+1];

  assign xe     = {{(AW-XW){x[XW-1]}}, x};
  assign acc[0] = '0;

  // one adder or subtractor per non-zero digit, nothing for zero digits
  for (genvar i = 0; i < ND; i++) begin : g_dig
    if (POS[i]) begin : g_add
      assign acc[i+1] = acc[i] + (xe << i);
    end else if (NEG[i]) begin : g_sub
      assign acc[i+1] = acc[i] - (xe << i);
    end else begin : g_pass
      assign acc[i+1] = acc[i];
    end
  end

  assign p = acc[ND];

endmodule

// File: rtl/fir_sample_mcm.sv
module fir_sample_mcm #(
  parameter int                    XW    = 8,
  parameter int                    CW    = 16,
  parameter int                    AW    = 24,
  parameter int                    LANES = 4,
  parameter int                    TAPS  = 16,
  parameter int                    SOFS  = 0,
  parameter logic [TAPS*CW-1:0]    COEFS = '0
) (
  input  logic signed [XW-1:0]      x,
  output logic        [TAPS*AW-1:0] prods
);

  // coefficient columns this window position meets
  localparam int JLO = (SOFS > LANES-1) ? SOFS-(LANES-1) : 0;
  localparam int JHI = (SOFS < LANES-1) ? SOFS : LANES-1;

  function automatic longint coef_at(input int c);
    logic signed [CW-1:0] t;
    t = COEFS[c*CW +: CW];
    return longint'(t);
  endfunction

  function automatic bit used(input int c);
    return ((c % LANES) >= JLO) && ((c % LANES) <= JHI);
  endfunction

  // first used coefficient with the same value: its network is shared
  function automatic int source_of(input int c);
    for (int f = 0; f < c; f++)
      if (used(f) && coef_at(f) == coef_at(c)) return f;
    return c;
  endfunction

  logic [AW-1:0] uniq [TAPS];

  for (genvar c = 0; c < TAPS; c++) begin : g_coef
    localparam bit USED = used(c);
    localparam int SRC  = source_of(c);
    if (USED && SRC == c) begin : g_own
      fir_csd_mult #(.XW(XW), .AW(AW), .COEF(coef_at(c))) u_mul (
        .x (x),
        .p (uniq[c])
      );
      assign prods[c*AW +: AW] = uniq[c];
    end else if (USED) begin : g_shared
      assign uniq[c]           = '0;
      assign prods[c*AW +: AW] = uniq[SRC];
    end else begin : g_none
      assign uniq[c]           = '0;
      assign prods[c*AW +: AW] = '0;
    end
  end

endmodule

// File: rtl/fir_xpose_chain.sv
module fir_xpose_chain #(
  parameter int LANES = 4,
  parameter int SEGS  = 4,
  parameter int AW    = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic [LANES*SEGS*AW-1:0]    part,
  output logic [LANES*AW-1:0]         y
);

  // stage 0 of each lane is the output register
  logic [AW-1:0] dly_q [LANES][SEGS];
  logic [AW-1:0] dly_d [LANES][SEGS];

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      for (int m = 0; m < SEGS; m++) begin
        if (!en)
          dly_d[l][m] = dly_q[l][m];
        else if (m < SEGS-1)
          dly_d[l][m] = part[(l*SEGS+m)*AW +: AW] + dly_q[l][m+1];
        else
          dly_d[l][m] = part[(l*SEGS+m)*AW +: AW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LANES; l++)
        for (int m = 0; m < SEGS; m++)
          dly_q[l][m] <= '0;
    end else begin
      dly_q <= dly_d;
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) y[l*AW +: AW] = dly_q[l][0];
  end

  // R4: an idle cycle leaves the results untouched
  p_chain_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(y));

endmodule

// File: rtl/fir_mcm_block.sv
module fir_mcm_block #(
  parameter int                 XW    = 8,
  parameter int                 CW    = 16,
  parameter int                 AW    = 24,
  parameter int                 LANES = 4,
  parameter int                 TAPS  = 16,
  parameter logic [TAPS*CW-1:0] COEFS = {16'h2EE0, 16'hFF01, 16'h04D2, 16'hF000,
                                         16'h0007, 16'h012C, 16'hAAAA, 16'h5555,
                                         16'hDCD8, 16'h04D2, 16'hFFFF, 16'h0205,
                                         16'h0000, 16'h7FFF, 16'h8000, 16'h04D2}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [LANES*XW-1:0]   in_samples,
  output logic                  out_valid,
  output logic [LANES*AW-1:0]   out_samples
);

  localparam int SEGS = TAPS / LANES;
  localparam int WIN  = 2*LANES - 1;
  localparam int HN   = LANES - 1;

  // reset: asserted at once, released two edges later
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // latest samples of the previous block: slot t holds x(4k-4-t)
  logic [HN*XW-1:0] hist_q, hist_d;

  always_comb begin
    for (int t = 0; t < HN; t++)
      hist_d[t*XW +: XW] = in_valid ? in_samples[(LANES-1-t)*XW +: XW]
                                    : hist_q[t*XW +: XW];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  // window slot s holds x(4k-s)
  logic signed [XW-1:0]   win  [WIN];
  logic [TAPS*AW-1:0]     prod [WIN];

  for (genvar s = 0; s < WIN; s++) begin : g_win
    if (s < LANES) begin : g_new
      assign win[s] = in_samples[(LANES-1-s)*XW +: XW];
    end else begin : g_old
      assign win[s] = hist_q[(s-LANES)*XW +: XW];
    end
    fir_sample_mcm #(
      .XW(XW), .CW(CW), .AW(AW), .LANES(LANES), .TAPS(TAPS),
      .SOFS(s), .COEFS(COEFS)
    ) u_mcm (
      .x     (win[s]),
      .prods (prod[s])
    );
  end

  // partial products: r(l,m) = sum_j x(4k-l-j) * h(4m+j)
  logic [LANES*SEGS*AW-1:0] part;

  always_comb begin
    logic [AW-1:0] acc;
    for (int l = 0; l < LANES; l++) begin
      for (int m = 0; m < SEGS; m++) begin
        acc = '0;
        for (int j = 0; j < LANES; j++)
          acc = acc + prod[l+j][(m*LANES+j)*AW +: AW];
        part[(l*SEGS+m)*AW +: AW] = acc;
      end
    end
  end

  logic [LANES*AW-1:0] y_by_age;

  fir_xpose_chain #(.LANES(LANES), .SEGS(SEGS), .AW(AW)) u_chain (
    .clk   (clk),
    .rst_n (rst_q),
    .en    (in_valid),
    .part  (part),
    .y     (y_by_age)
  );

  // chain lane l is x(4k-l); port lane i is the i-th earliest
  for (genvar i = 0; i < LANES; i++) begin : g_out
    assign out_samples[i*AW +: AW] = y_by_age[(LANES-1-i)*AW +: AW];
  end

  logic vld_d;
  assign vld_d = in_valid;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) out_valid <= 1'b0;
    else        out_valid <= vld_d;
  end

  // R3: one cycle from an accepted block to its results
  p_out_valid_lat_r3: assert property (@(posedge clk) disable iff (!rst_q)
    $past(in_valid) |-> out_valid);

  // R4: no results after an idle cycle
  p_idle_no_valid_r4: assert property (@(posedge clk) disable iff (!rst_q)
    !$past(in_valid) |-> !out_valid);

  // R4: stored samples do not move during an idle cycle
  p_hist_hold_r4: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> $stable(hist_q));

  // R4: results stay on the port through an idle cycle
  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> $stable(out_samples));

endmodule

// File: tb/sim_fir_mcm_block.sv
module sim_fir_mcm_block;

  localparam int XW = 8, CW = 16, AW = 24, LANES = 4, TAPS = 16;
  localparam logic [TAPS*CW-1:0] TB_COEFS =
    {16'h2EE0, 16'hFF01, 16'h04D2, 16'hF000, 16'h0007, 16'h012C, 16'hAAAA, 16'h5555,
     16'hDCD8, 16'h04D2, 16'hFFFF, 16'h0205, 16'h0000, 16'h7FFF, 16'h8000, 16'h04D2};

  int H [TAPS] = '{1234, -32768, 32767, 0, 517, -1, 1234, -9000,
                   21845, -21846, 300, 7, -4096, 1234, -255, 12000};

  logic                 clk;
  logic                 rst_n;
  logic                 in_valid;
  logic [LANES*XW-1:0]  in_samples;
  logic                 out_valid;
  logic [LANES*AW-1:0]  out_samples;

  fir_mcm_block #(.XW(XW), .CW(CW), .AW(AW), .LANES(LANES), .TAPS(TAPS),
                  .COEFS(TB_COEFS)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
    .out_valid(out_valid), .out_samples(out_samples));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int          n_vec = 0, n_bad = 0;
  longint      xs [TAPS];
  logic [AW-1:0] exp_y [LANES];
  bit          exp_v;
  string       exp_tag;

  task automatic model_clear();
    for (int i = 0; i < TAPS; i++) xs[i] = 0;
    for (int i = 0; i < LANES; i++) exp_y[i] = '0;
    exp_v = 1'b0;
  endtask

  function automatic logic [AW-1:0] model_push(input int s);
    longint acc;
    for (int i = TAPS-1; i > 0; i--) xs[i] = xs[i-1];
    xs[0] = s;
    acc = 0;
    for (int i = 0; i < TAPS; i++) acc += longint'(H[i]) * xs[i];
    return acc[AW-1:0];
  endfunction

  task automatic check();
    n_vec++;
    if (out_valid !== exp_v) begin
      n_bad++;
      $display("FAIL %s out_valid actual %0b expected %0b", exp_tag, out_valid, exp_v);
    end
    for (int i = 0; i < LANES; i++) begin
      n_vec++;
      if (out_samples[i*AW +: AW] !== exp_y[i]) begin
        n_bad++;
        $display("FAIL %s lane %0d actual %0d expected %0d", exp_tag, i,
                 $signed(out_samples[i*AW +: AW]), $signed(exp_y[i]));
      end
    end
  endtask

  task automatic step(input bit v, input int s0, input int s1, input int s2,
                      input int s3, input string tag);
    @(negedge clk);
    check();
    in_valid   = v;
    in_samples = {8'(s3), 8'(s2), 8'(s1), 8'(s0)};
    if (v) begin
      exp_y[0] = model_push(s0);
      exp_y[1] = model_push(s1);
      exp_y[2] = model_push(s2);
      exp_y[3] = model_push(s3);
    end
    exp_v   = v;
    exp_tag = tag;
  endtask

  function automatic int rnd8();
    return int'($urandom_range(0, 255)) - 128;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    check();
    rst_n    = 1'b0;
    in_valid = 1'b0;
    model_clear();
    exp_tag = "R1";
    repeat (3) begin
      @(negedge clk);
      check();
    end
    rst_n = 1'b1;
    repeat (4) step(1'b0, 0, 0, 0, 0, "R1");
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seq [TAPS];
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    in_samples = '0;
    model_clear();
    exp_tag = "R1";
    repeat (3) begin
      @(negedge clk);
      check();                                   // R1 outputs cleared in reset
    end
    rst_n = 1'b1;
    repeat (4) step(1'b0, 0, 0, 0, 0, "R1");

    // R8: unit impulse reproduces the coefficients in order
    step(1'b1, 1, 0, 0, 0, "R8");
    repeat (5) step(1'b1, 0, 0, 0, 0, "R8");

    // R6: full-scale negative sample against extreme coefficients
    step(1'b1, 0, -128, 0, 0, "R6");
    repeat (5) step(1'b1, 0, 0, 0, 0, "R6");

    // R5: impulses in the latest lanes cross block boundaries
    step(1'b1, 0, 0, 0, 100, "R5");
    repeat (4) step(1'b1, 0, 0, 0, 0, "R5");
    step(1'b1, 0, 0, -77, 0, "R5");
    repeat (4) step(1'b1, 0, 0, 0, 0, "R5");

    // R3: a single block then idle, result one cycle later
    step(1'b1, 5, 6, 7, 8, "R3");
    step(1'b0, 0, 0, 0, 0, "R3");
    step(1'b0, 0, 0, 0, 0, "R4");

    // R2: random full-scale blocks back to back
    for (int b = 0; b < 150; b++)
      step(1'b1, rnd8(), rnd8(), rnd8(), rnd8(), "R2");

    // R4: random blocks with idle gaps, input garbage while idle
    for (int b = 0; b < 150; b++)
      step(1'($urandom_range(0, 1)), rnd8(), rnd8(), rnd8(), rnd8(), "R4");

    // R7: samples aligned with coefficient signs so the sum wraps
    for (int t = 0; t < TAPS; t++) seq[t] = (H[TAPS-1-t] >= 0) ? 127 : -128;
    for (int b = 0; b < TAPS/LANES; b++)
      step(1'b1, seq[4*b], seq[4*b+1], seq[4*b+2], seq[4*b+3], "R7");
    repeat (4) step(1'b1, 0, 0, 0, 0, "R7");

    // R1: reset in mid-stream wipes the stored history
    repeat (5) step(1'b1, rnd8(), rnd8(), rnd8(), rnd8(), "R2");
    do_reset();
    repeat (4) step(1'b1, 0, 0, 0, 0, "R1");
    step(1'b0, 0, 0, 0, 0, "R1");
    @(negedge clk);
    check();
    finish_run();
  end

endmodule